// File: doc/BRIEF.md
# Five-Share GF(16) Inverter

This block computes the multiplicative inverse in GF(16) while the operand never exists in plain form inside the circuit. Each of the four input bits arrives as five Boolean shares whose XOR is the true bit. Each of the four result bits leaves as five shares in the same way. No fresh randomness is drawn during the computation. Every output share function reads at most four of the five share indices, so a fault or glitch inside one share function sees no complete operand. A single register stage closes the block, so glitches cannot run into the next stage.

The field is built as a tower. GF(4) is GF(2)[t]/(t^2+t+1), and GF(16) is GF(4)[s]/(s^2+s+t). An element is packed as a 4-bit value with bit 3 = x, bit 2 = y, bit 1 = z, bit 0 = v, meaning (x·t+y)·s+(z·t+v). The result is packed the same way as (f·t+g)·s+(h·t+k). The share logic comes from the algebraic normal form of the inversion map, which has degree 3. Each product of shares is placed in an output share whose index that product does not use. Share generation and recombination are done by the user of the block.

Top module: `gf16_share_inv`

## Requirements
- R1: The XOR of the five shares of each output bit, packed as {f,g,h,k}, equals the GF(16) inverse of the packed recombined input {x,y,z,v} in the tower representation above.
- R2: The recombined input 0 produces the recombined output 0.
- R3: Output share i of f, g, h and k (i = 0..4) does not depend on input share i of x, y, z or v.
- R4: Output shares are registered and change at the first rising clock edge where in_valid is high. out_valid is high for exactly the cycle after each such edge, that is, it follows in_valid with one cycle of delay.
- R5: While in_valid is low, the output shares keep their values, whatever the input shares carry.
- R6: When rst_n is low at a rising clock edge, all output shares and out_valid are cleared to 0 (synchronous, active-low reset).
- R7: Different sharings of the same input value give the same recombined output.
- R8: A nonzero recombined input always gives a nonzero recombined output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input shares are valid this cycle |
| in_x | input | 5 | Shares of input bit x (t·s coefficient) |
| in_y | input | 5 | Shares of input bit y (s coefficient) |
| in_z | input | 5 | Shares of input bit z (t coefficient) |
| in_v | input | 5 | Shares of input bit v (constant term) |
| out_valid | output | 1 | Output shares were loaded at the previous edge |
| out_f | output | 5 | Shares of result bit f |
| out_g | output | 5 | Shares of result bit g |
| out_h | output | 5 | Shares of result bit h |
| out_k | output | 5 | Shares of result bit k |

## Verification
The hardest property to observe at the ports is non-completeness. A wrong share placement still recombines to the correct inverse, so it does not show up in the recombined result. To expose it, the bench drives a random sharing, records output share i, and then redraws only share index i of every input. This changes the operand value, yet output share i must not move. The bench does this for every index and for several base sharings. All sixteen values are also driven under many random sharings, so that placement errors affecting correctness show up as well.

// File: rtl/gf16_share_inv.sv
module gf16_share_inv #(
  parameter int NSH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [NSH-1:0] in_x,
  input  logic [NSH-1:0] in_y,
  input  logic [NSH-1:0] in_z,
  input  logic [NSH-1:0] in_v,
  output logic           out_valid,
  output logic [NSH-1:0] out_f,
  output logic [NSH-1:0] out_g,
  output logic [NSH-1:0] out_h,
  output logic [NSH-1:0] out_k
);

  localparam int NB = 4;
  localparam int NE = 1 << NB;

  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] r;
    r[1] = (a[1] & b[0]) ^ (a[0] & b[1]) ^ (a[1] & b[1]);
    r[0] = (a[0] & b[0]) ^ (a[1] & b[1]);
    return r;
  endfunction

  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] ac;
    logic [3:0] r;
    ac = gf4_mul(a[3:2], b[3:2]);
    r[3:2] = gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]) ^ ac;
    r[1:0] = gf4_mul(a[1:0], b[1:0]) ^ gf4_mul(ac, 2'b10);
    return r;
  endfunction

  function automatic logic [3:0] gf16_inv(input logic [3:0] a);
    logic [3:0] r;
    r = '0;
    for (int c = 1; c < NE; c++)
      if (gf16_mul(a, 4'(c)) == 4'd1) r = 4'(c);
    return r;
  endfunction

  // algebraic normal form coefficients, bit b*NE+m = coefficient of monomial m in output bit b
  function automatic logic [NB*NE-1:0] anf_table();
    logic [NB*NE-1:0] t;
    logic [3:0] iv;
    t = '0;
    for (int b = 0; b < NB; b++)
      for (int m = 0; m < NE; m++)
        for (int u = 0; u < NE; u++)
          if ((u & ~m) == 0) begin
            iv = gf16_inv(4'(u));
            t[b*NE+m] = t[b*NE+m] ^ iv[b];
          end
    return t;
  endfunction

  localparam logic [NB*NE-1:0] ANF = anf_table();

  function automatic int spare_share(input int i, input int j, input int l);
    int r;
    r = 0;
    for (int k = 0; k < NSH; k++)
      if (k != i && k != j && k != l) r = k;
    return r;
  endfunction

  function automatic logic [NSH-1:0] share_eval(
    input logic [NSH-1:0] sx, input logic [NSH-1:0] sy,
    input logic [NSH-1:0] sz, input logic [NSH-1:0] sv, input int b);
    logic [NSH-1:0] acc;
    logic [NSH-1:0] sh [NB];
    int vs [3];
    int cnt;
    int jj;
    int ll;
    logic term;
    acc = '0;
    sh[3] = sx; sh[2] = sy; sh[1] = sz; sh[0] = sv;
    for (int m = 1; m < NE; m++) begin
      if (ANF[b*NE+m]) begin
        cnt = 0;
        vs[0] = 0; vs[1] = 0; vs[2] = 0;
        for (int q = 0; q < NB; q++)
          if (((m >> q) & 1) != 0 && cnt < 3) begin
            vs[cnt] = q;
            cnt++;
          end
        for (int i = 0; i < NSH; i++)
          for (int j = 0; j < NSH; j++)
            for (int l = 0; l < NSH; l++)
              if ((cnt > 1 || j == 0) && (cnt > 2 || l == 0)) begin
                jj = (cnt > 1) ? j : i;
                ll = (cnt > 2) ? l : i;
                term = sh[vs[0]][i];
                if (cnt > 1) term = term & sh[vs[1]][j];
                if (cnt > 2) term = term & sh[vs[2]][l];
                acc[spare_share(i, jj, ll)] ^= term;
              end
      end
    end
    return acc;
  endfunction

  logic [NSH-1:0] nxt_f, nxt_g, nxt_h, nxt_k;

  assign nxt_f = share_eval(in_x, in_y, in_z, in_v, 3);
  assign nxt_g = share_eval(in_x, in_y, in_z, in_v, 2);
  assign nxt_h = share_eval(in_x, in_y, in_z, in_v, 1);
  assign nxt_k = share_eval(in_x, in_y, in_z, in_v, 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_f <= '0;
      out_g <= '0;
      out_h <= '0;
      out_k <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_f <= nxt_f;
        out_g <= nxt_g;
        out_h <= nxt_h;
        out_k <= nxt_k;
      end
    end
  end

endmodule

// File: rtl/gf16_share_inv_chk.sv
module gf16_share_inv_chk #(
  parameter int NSH = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [NSH-1:0] in_x,
  input logic [NSH-1:0] in_y,
  input logic [NSH-1:0] in_z,
  input logic [NSH-1:0] in_v,
  input logic           out_valid,
  input logic [NSH-1:0] out_f,
  input logic [NSH-1:0] out_g,
  input logic [NSH-1:0] out_h,
  input logic [NSH-1:0] out_k
);
  logic [3:0] in_val, out_val;
  assign in_val  = {^in_x, ^in_y, ^in_z, ^in_v};
  assign out_val = {^out_f, ^out_g, ^out_h, ^out_k};

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_f) && $stable(out_g) && $stable(out_h) && $stable(out_k)));

  // R2
  zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_val) == 4'd0) |-> out_val == 4'd0);

  // R8
  nonzero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_val) != 4'd0) |-> out_val != 4'd0);
endmodule

bind gf16_share_inv gf16_share_inv_chk #(.NSH(NSH)) chk_i (.*);

// File: tb/gf16_share_inv_tb_top.sv
module gf16_share_inv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NSH-1:0] in_x = '0, in_y = '0, in_z = '0, in_v = '0;
  logic out_valid;
  logic [NSH-1:0] out_f, out_g, out_h, out_k;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf16_share_inv #(.NSH(NSH)) dut_i (.*);

  function automatic logic [1:0] m4(input logic [1:0] a, input logic [1:0] b);
    return {(a[1]&b[0])^(a[0]&b[1])^(a[1]&b[1]), (a[0]&b[0])^(a[1]&b[1])};
  endfunction

  function automatic logic [3:0] m16(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = m4(a[3:2], b[3:2]);
    return {m4(a[3:2], b[1:0]) ^ m4(a[1:0], b[3:2]) ^ hh, m4(a[1:0], b[1:0]) ^ m4(hh, 2'b10)};
  endfunction

  function automatic logic [3:0] ref_inv(input logic [3:0] a);
    logic [3:0] p;
    p = 4'd1;
    for (int e = 0; e < 14; e++) p = m16(p, a);
    return p;
  endfunction

  function automatic logic [NSH-1:0] split(input logic b);
    logic [NSH-1:0] s;
    s = NSH'($urandom);
    s[NSH-1] = ^s[NSH-2:0] ^ b;
    return s;
  endfunction

  function automatic logic [3:0] rec();
    return {^out_f, ^out_g, ^out_h, ^out_k};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [NSH-1:0] xs, ys, zs, vs);
    @(negedge clk);
    in_x = xs; in_y = ys; in_z = zs; in_v = vs;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drive_val(input logic [3:0] a);
    drive(split(a[3]), split(a[2]), split(a[1]), split(a[0]));
  endtask

  initial begin
    logic [NSH-1:0] bx, by, bz, bv, sf, sg, sh, sk;
    logic [3:0] first;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R6 reset state
    check(out_valid == 1'b0, "R6 valid", out_valid, 0);
    check({out_f, out_g, out_h, out_k} == '0, "R6 shares", {out_f, out_g, out_h, out_k}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R7 R8 R4 over all values, several sharings each
    for (int a = 0; a < 16; a++) begin
      for (int r = 0; r < 8; r++) begin
        drive_val(4'(a));
        check(out_valid == 1'b1, "R4 valid", out_valid, 1);
        check(rec() == ref_inv(4'(a)), "R1 inverse", rec(), ref_inv(4'(a)));
        if (r == 0) first = rec();
        else check(rec() == first, "R7 sharing", rec(), first);
        if (a == 0) check(rec() == 4'd0, "R2 zero", rec(), 0);
        else check(rec() != 4'd0, "R8 nonzero", rec(), 1);
      end
    end

    // R4 out_valid drops one cycle after in_valid drops; R5 hold while idle
    drive_val(4'd7);
    first = rec();
    {sf, sg, sh, sk} = {out_f, out_g, out_h, out_k};
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_x = NSH'($urandom); in_y = NSH'($urandom); in_z = NSH'($urandom); in_v = NSH'($urandom);
      @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R4 valid low", out_valid, 0);
      check({out_f, out_g, out_h, out_k} == {sf, sg, sh, sk}, "R5 hold",
            {out_f, out_g, out_h, out_k}, {sf, sg, sh, sk});
    end

    // R3 non-completeness: redraw share index o of every input only
    for (int o = 0; o < NSH; o++) begin
      for (int r = 0; r < 6; r++) begin
        bx = NSH'($urandom); by = NSH'($urandom); bz = NSH'($urandom); bv = NSH'($urandom);
        drive(bx, by, bz, bv);
        {sf, sg, sh, sk} = {out_f, out_g, out_h, out_k};
        bx[o] = ~bx[o];
        by[o] = by[o] ^ 1'($urandom);
        bz[o] = bz[o] ^ 1'($urandom);
        bv[o] = bv[o] ^ 1'($urandom);
        drive(bx, by, bz, bv);
        check({out_f[o], out_g[o], out_h[o], out_k[o]} == {sf[o], sg[o], sh[o], sk[o]}, "R3 share",
              {out_f[o], out_g[o], out_h[o], out_k[o]}, {sf[o], sg[o], sh[o], sk[o]});
      end
    end

    // R6 reset during a valid cycle
    drive_val(4'd9);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_x = split(1'b1); in_y = split(1'b0); in_z = split(1'b1); in_v = split(1'b1);
    @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R6 valid mid", out_valid, 0);
    check({out_f, out_g, out_h, out_k} == '0, "R6 shares mid", {out_f, out_g, out_h, out_k}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule